// File: doc/BRIEF.md
# Doorbell and MSI Trigger Unit

This unit holds a bank of doorbell state for each of several CPUs: a 32-bit pending (cause) register and a 32-bit enable (mask) register per CPU. A single global trigger register lets one CPU ring a numbered doorbell on any set of CPUs at once. The trigger word carries both the doorbell number and the target-CPU bitmap. Inbound PCIe MSI writes are routed to the same trigger and use the same word format, with the doorbell number set to 16 plus the MSI vector.

Each CPU gets two level-sensitive summary lines. The IPI line covers doorbells 0 to 7, and the MSI line covers doorbells 16 to 31. A line is high while any doorbell in its range is both pending and enabled. The IPI line feeds source 0 of the main interrupt controller and the MSI line feeds source 1.

The cause and mask registers are banked by the CPU that makes the access. Software acknowledges a doorbell by writing the cause register with a 0 in that bit position and 1s everywhere else.

Top module: `doorbell_unit`

## Requirements
- R1: After reset every cause and mask register reads 0x00000000 and all ipi_irq_o and msi_irq_o bits are low.
- R2: A register write to offset 0x04 sets cause bit N in every CPU c whose target bit wdata_i[8+c] is 1, where N = wdata_i[4:0]. Cause bits of other CPUs, and all other cause bits, keep their values.
- R3: A trigger whose target field [11:8] is zero changes no cause register.
- R4: When msi_valid_i is high, msi_data_i is decoded exactly like a trigger word. A software trigger and an MSI trigger in the same cycle both take effect.
- R5: A write to offset 0x08 by CPU cpu_i clears each cause bit of that CPU written as 0 and keeps each bit written as 1. Other CPUs' cause registers are untouched.
- R6: A write to offset 0x0C by CPU cpu_i replaces that CPU's mask register with wdata_i. Other CPUs' mask registers are untouched.
- R7: If a trigger sets a cause bit in the same cycle that a cause write clears it, the bit ends up set.
- R8: ipi_irq_o[c] is the OR over bits 7:0 of cause AND mask of CPU c. Doorbells 8 to 15 drive neither summary line.
- R9: msi_irq_o[c] is the OR over bits 31:16 of cause AND mask of CPU c.
- R10: A read with rd_en_i returns, on rdata_o in the next cycle, the cause (offset 0x08) or mask (offset 0x0C) register of CPU cpu_i. Any other offset returns 0.
- R11: Trigger, cause-write and mask-write effects appear on the summary outputs right after the clock edge that accepts them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the access |
| cpu_i | input | 2 | Requesting CPU; selects the bank |
| wdata_i | input | 32 | Write data |
| msi_valid_i | input | 1 | Inbound MSI write to the trigger |
| msi_data_i | input | 32 | MSI data word in trigger format |
| rdata_o | output | 32 | Read data, valid one cycle after rd_en_i |
| ipi_irq_o | output | 4 | Per-CPU IPI summary (doorbells 0 to 7) |
| msi_irq_o | output | 4 | Per-CPU MSI summary (doorbells 16 to 31) |

## Verification
Write and trigger effects are registered on the edge that accepts them, and the summary lines are combinational from those registers. The bench therefore drives each operation on a falling edge and compares both summary vectors at the next falling edge. Read data is registered too, so every readback is sampled one falling edge after the read strobe, by which time all earlier writes have settled. The main sweep covers every combination of doorbell number and target bitmap, alternating between the software and MSI trigger paths. It compares against a per-CPU model that the bench updates arithmetically for each operation.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  parameter logic [7:0]  TRIG_OFFS  = 8'h04;
  parameter logic [7:0]  CAUSE_OFFS = 8'h08;
  parameter logic [7:0]  MASK_OFFS  = 8'h0C;
  parameter int          TGT_LSB    = 8;
  parameter logic [31:0] IPI_RANGE  = 32'h0000_00FF;
  parameter logic [31:0] MSI_RANGE  = 32'hFFFF_0000;
endpackage

// File: rtl/dbell_trig_dec.sv
module dbell_trig_dec #(
  parameter int NCPU = 4,
  parameter int DB_W = 32,
  localparam int NUM_W = $clog2(DB_W)
) (
  input  logic                  valid_i,
  input  logic [NUM_W-1:0]      num_i,
  input  logic [NCPU-1:0]       tgt_i,
  output logic [NCPU-1:0][DB_W-1:0] set_o
);
  logic [DB_W-1:0] onehot;

  always_comb begin
    onehot = '0;
    onehot[num_i] = 1'b1;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign set_o[c] = (valid_i && tgt_i[c]) ? onehot : '0;
  end
endmodule

// File: rtl/dbell_bank.sv
module dbell_bank #(
  parameter int              DB_W      = 32,
  parameter logic [DB_W-1:0] IPI_RANGE = '0,
  parameter logic [DB_W-1:0] MSI_RANGE = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DB_W-1:0] set_i,
  input  logic            clr_en_i,
  input  logic [DB_W-1:0] clr_data_i,
  input  logic            mask_we_i,
  input  logic [DB_W-1:0] mask_data_i,
  output logic [DB_W-1:0] cause_o,
  output logic [DB_W-1:0] mask_o,
  output logic            ipi_o,
  output logic            msi_o
);
  logic [DB_W-1:0] cause_q, mask_q, cause_d, active;

  always_comb begin
    cause_d = clr_en_i ? (cause_q & clr_data_i) : cause_q;
    cause_d = cause_d | set_i;  // set beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= cause_d;
      if (mask_we_i) mask_q <= mask_data_i;
    end
  end

  assign active  = cause_q & mask_q;
  assign ipi_o   = |(active & IPI_RANGE);
  assign msi_o   = |(active & MSI_RANGE);
  assign cause_o = cause_q;
  assign mask_o  = mask_q;

  assert_set_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((cause_q & $past(set_i)) == $past(set_i)));

  assert_clear_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((cause_q & ~($past(clr_data_i) | $past(set_i))) == '0));

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_en_i && set_i == '0) |=> $stable(cause_q));

  assert_mask_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_q == $past(mask_data_i)));

  assert_mask_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit #(
  parameter int NCPU   = 4,
  parameter int DB_W   = 32,
  parameter int ADDR_W = 8,
  localparam int CPU_W = $clog2(NCPU),
  localparam int NUM_W = $clog2(DB_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CPU_W-1:0]  cpu_i,
  input  logic [DB_W-1:0]   wdata_i,
  input  logic              msi_valid_i,
  input  logic [DB_W-1:0]   msi_data_i,
  output logic [DB_W-1:0]   rdata_o,
  output logic [NCPU-1:0]   ipi_irq_o,
  output logic [NCPU-1:0]   msi_irq_o
);
  import dbell_pkg::*;

  localparam int TGT_HI = TGT_LSB + NCPU;

  logic sw_trig, cause_hit, mask_hit;
  logic [NCPU-1:0][DB_W-1:0] sw_set, msi_set, cause, mask;
  logic [DB_W-1:0] rdata_q;
  logic unused_bits;

  assign sw_trig   = wr_en_i && (addr_i == ADDR_W'(TRIG_OFFS));
  assign cause_hit = (addr_i == ADDR_W'(CAUSE_OFFS));
  assign mask_hit  = (addr_i == ADDR_W'(MASK_OFFS));

  assign unused_bits = ^{msi_data_i[DB_W-1:TGT_HI], msi_data_i[TGT_LSB-1:NUM_W]};

  dbell_trig_dec #(.NCPU(NCPU), .DB_W(DB_W)) u_sw_dec (
    .valid_i (sw_trig),
    .num_i   (wdata_i[NUM_W-1:0]),
    .tgt_i   (wdata_i[TGT_HI-1:TGT_LSB]),
    .set_o   (sw_set)
  );

  dbell_trig_dec #(.NCPU(NCPU), .DB_W(DB_W)) u_msi_dec (
    .valid_i (msi_valid_i),
    .num_i   (msi_data_i[NUM_W-1:0]),
    .tgt_i   (msi_data_i[TGT_HI-1:TGT_LSB]),
    .set_o   (msi_set)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_bank
    logic own;
    assign own = (cpu_i == CPU_W'(c));

    dbell_bank #(
      .DB_W      (DB_W),
      .IPI_RANGE (DB_W'(IPI_RANGE)),
      .MSI_RANGE (DB_W'(MSI_RANGE))
    ) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .set_i       (sw_set[c] | msi_set[c]),
      .clr_en_i    (wr_en_i && cause_hit && own),
      .clr_data_i  (wdata_i),
      .mask_we_i   (wr_en_i && mask_hit && own),
      .mask_data_i (wdata_i),
      .cause_o     (cause[c]),
      .mask_o      (mask[c]),
      .ipi_o       (ipi_irq_o[c]),
      .msi_o       (msi_irq_o[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      if (cause_hit)     rdata_q <= cause[cpu_i];
      else if (mask_hit) rdata_q <= mask[cpu_i];
      else               rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;

  assert_rd_other_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !cause_hit && !mask_hit) |=> (rdata_o == '0));

  assert_rd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/doorbell_unit_tb_top.sv
`timescale 1ns/1ps
module doorbell_unit_tb_top;
  localparam int NCPU = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 0, rd_en = 0, msi_valid = 0;
  logic [7:0] addr = '0;
  logic [1:0] cpu_s = '0;
  logic [31:0] wdata = '0, msi_data = '0;
  logic [31:0] rdata;
  logic [3:0] ipi_irq, msi_irq;

  logic [31:0] cause_m [NCPU];
  logic [31:0] mask_m  [NCPU];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  doorbell_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .cpu_i(cpu_s), .wdata_i(wdata),
    .msi_valid_i(msi_valid), .msi_data_i(msi_data),
    .rdata_o(rdata), .ipi_irq_o(ipi_irq), .msi_irq_o(msi_irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] trig_bits(logic [31:0] d, int c);
    return d[8+c] ? (32'h1 << d[4:0]) : 32'h0;
  endfunction

  // one bus cycle; inputs driven after a falling edge, released at the next
  task automatic cyc(bit wr, bit rd, logic [7:0] a, int cpu, logic [31:0] d,
                     bit mv, logic [31:0] md);
    wr_en = wr; rd_en = rd; addr = a; cpu_s = cpu[1:0]; wdata = d;
    msi_valid = mv; msi_data = md;
    for (int c = 0; c < NCPU; c++) begin
      logic [31:0] s;
      s = '0;
      if (wr && a == 8'h04) s |= trig_bits(d, c);
      if (mv) s |= trig_bits(md, c);
      if (wr && a == 8'h08 && cpu == c) cause_m[c] &= d;
      cause_m[c] |= s;
      if (wr && a == 8'h0C && cpu == c) mask_m[c] = d;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; msi_valid = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, int cpu, logic [31:0] exp);
    cyc(0, 1, a, cpu, '0, 0, '0);
    chk(req, $sformatf("read off %h cpu %0d", a, cpu), rdata, exp);
  endtask

  task automatic irq_chk(string req);
    logic [3:0] ei, em;
    for (int c = 0; c < NCPU; c++) begin
      ei[c] = |(cause_m[c] & mask_m[c] & 32'h0000_00FF);
      em[c] = |(cause_m[c] & mask_m[c] & 32'hFFFF_0000);
    end
    chk(req, "ipi_irq", {28'h0, ipi_irq}, {28'h0, ei});
    chk(req, "msi_irq", {28'h0, msi_irq}, {28'h0, em});
  endtask

  task automatic all_chk(string req);
    irq_chk(req);
    for (int c = 0; c < NCPU; c++) begin
      rd_chk(req, 8'h08, c, cause_m[c]);
      rd_chk(req, 8'h0C, c, mask_m[c]);
    end
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCPU; c++) begin cause_m[c] = '0; mask_m[c] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    all_chk("R1");

    // R6 banked mask load
    for (int c = 0; c < NCPU; c++) cyc(1, 0, 8'h0C, c, 32'hFFFF_FFFF, 0, '0);
    all_chk("R6");

    // R2 R3 R4 R8 R9 R11: every doorbell number x every target field
    for (int n = 0; n < 32; n++) begin
      for (int t = 0; t < 16; t++) begin
        logic [31:0] d;
        d = {20'h0, t[3:0], 3'b000, n[4:0]};
        if (((n + t) % 2) == 1) cyc(0, 0, 8'h00, 0, '0, 1, d);   // R4 MSI path
        else                    cyc(1, 0, 8'h04, 0, d, 0, '0);   // R2 sw path
        irq_chk((t == 0) ? "R3" : "R8_R9_R11");
        for (int c = 0; c < NCPU; c++) rd_chk(t == 0 ? "R3" : "R2", 8'h08, c, cause_m[c]);
        for (int c = 0; c < NCPU; c++) cyc(1, 0, 8'h08, c, 32'h0, 0, '0);
      end
    end
    irq_chk("R5");

    // R4 both sources same cycle
    cyc(1, 0, 8'h04, 0, 32'h0000_0503, 1, 32'h0000_0A14);
    all_chk("R4");

    // R5 clear-on-zero, banked
    for (int c = 0; c < NCPU; c++) cyc(1, 0, 8'h04, 0, 32'h0000_0F00 | c, 0, '0);
    cyc(1, 0, 8'h04, 0, 32'h0000_0F1F, 0, '0);
    cyc(1, 0, 8'h08, 2, 32'hFFFF_FFFA, 0, '0);
    all_chk("R5");

    // R7 set wins over clear in the same cycle
    cyc(1, 0, 8'h04, 0, 32'h0000_0202, 0, '0);
    cyc(1, 1, 8'h08, 1, 32'h0000_0000, 1, 32'h0000_0202);
    rd_chk("R7", 8'h08, 1, 32'h0000_0004);
    irq_chk("R7");

    // R8 R9 mask gating
    for (int c = 0; c < NCPU; c++) cyc(1, 0, 8'h08, c, 32'h0, 0, '0);
    cyc(1, 0, 8'h04, 0, 32'h0000_0F0A, 0, '0);
    cyc(1, 0, 8'h04, 0, 32'h0000_0F1C, 0, '0);
    cyc(1, 0, 8'h0C, 0, 32'h0000_FF00, 0, '0);
    cyc(1, 0, 8'h0C, 1, 32'h0000_0000, 0, '0);
    cyc(1, 0, 8'h0C, 2, 32'h1000_0000, 0, '0);
    cyc(1, 0, 8'h0C, 3, 32'h0001_0000, 0, '0);
    chk("R8", "ipi_irq gated", {28'h0, ipi_irq}, 32'h0);
    chk("R9", "msi_irq gated", {28'h0, msi_irq}, 32'h4);
    cyc(1, 0, 8'h04, 0, 32'h0000_0810, 0, '0);
    chk("R9", "msi_irq cpu3", {28'h0, msi_irq}, 32'hC);
    cyc(1, 0, 8'h0C, 0, 32'h0000_0001, 0, '0);
    cyc(1, 0, 8'h04, 0, 32'h0000_0100, 0, '0);
    chk("R8", "ipi_irq cpu0", {28'h0, ipi_irq}, 32'h1);
    all_chk("R8");

    // R10 other offsets read zero
    rd_chk("R10", 8'h04, 0, 32'h0);
    rd_chk("R10", 8'h00, 2, 32'h0);
    rd_chk("R10", 8'h10, 3, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule